// File: doc/BRIEF.md
# Multi-bank FFT operand fetch address generator

This block drives the read side of a 16-bank operand memory for an FFT data-path. After a start pulse it runs one pass of 4,096 cycles. On each cycle of the pass it names one bank pair, an even bank and the odd bank above it, and one word address that both banks of the pair share. A pass therefore reads 8,192 samples. The memory arrays, the butterfly, twiddle factors and write-back addressing sit outside this block.

Three fetch orders are available, one per butterfly radix. In radix-2 order the block reads one pair from top to bottom, then moves to the next pair. In radix-4 and radix-8 orders, two or four neighbouring pairs form a unit. Inside a unit the active pair rotates on every cycle, and the word address moves on only once every pair of the unit has been read at that address. When a unit has been read out, the address wraps to zero and the next unit starts.

Top module: `fft_fetch_agen`

## Requirements
- R1: While rst_n is low, and after it is released until the first start, fetch_valid and pass_done are 0 and bank_lo, bank_hi and word_addr are 0.
- R2: A start pulse seen while no pass runs makes fetch_valid 1 from the next cycle on, for exactly 4,096 consecutive cycles. The pass counter t then runs from 0 to 4095.
- R3: pass_done is 1 for exactly one cycle, the cycle right after the last valid cycle. Whenever fetch_valid is 0, the bank and address outputs are 0. A start given in the pass_done cycle is accepted.
- R4: radix_sel is decoded as 00 radix-2, 01 radix-4, 10 radix-8 and 11 radix-2. It is sampled only with an accepted start. Changes to radix_sel, and further start pulses, during a pass have no effect on that pass.
- R5: While valid, the output pair p is given as bank_lo = 2p and bank_hi = 2p+1.
- R6: Radix-2 (m=1): p = t/512 and word_addr = t mod 512. The pair is held for 512 cycles while the address rises by one on every cycle.
- R7: Radix-4 (m=2): p = 2*(t/1024) + (t mod 2) and word_addr = (t/2) mod 512. The pair alternates inside its unit on every cycle.
- R8: Radix-8 (m=4): p = 4*(t/2048) + (t mod 4) and word_addr = (t/4) mod 512. The pair rotates through the four pairs of its unit.
- R9: At each unit boundary inside a pass, word_addr wraps from 511 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a pass when no pass runs |
| radix_sel | input | 2 | Fetch order select |
| fetch_valid | output | 1 | Bank and address outputs name a fetch |
| bank_lo | output | 4 | Even bank of the active pair |
| bank_hi | output | 4 | Odd bank of the active pair |
| word_addr | output | 9 | Word address shared by both banks |
| pass_done | output | 1 | One-cycle pulse after the last fetch |

## Verification
On every cycle, the assertions check the local step rules of each order. In radix-2 the address steps by one and the pair holds while the address is non-zero. In radix-4 the pair alternates, and in radix-8 it rotates by one. The mode register is held through a pass, extra starts are ignored, and pass_done lasts one cycle. Only the bench's scenarios can show the full mapping against the pass counter: the exact pass length, the unit order across the whole bank range, and the wrap points. They can also show that a radix change in mid-pass leaves the running pass untouched and that a start in the done cycle is taken. The bench covers these with a back-to-back sequence of passes in all four select codes.

// File: rtl/fft_fetch_pkg.sv
package fft_fetch_pkg;

  typedef enum logic [1:0] {
    RDX_2   = 2'b00,
    RDX_4   = 2'b01,
    RDX_8   = 2'b10,
    RDX_RSV = 2'b11
  } radix_sel_e;

  // log2 of the number of pairs in one unit
  function automatic logic [1:0] unit_lg(input logic [1:0] sel);
    case (sel)
      RDX_4:   unit_lg = 2'd1;
      RDX_8:   unit_lg = 2'd2;
      default: unit_lg = 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/fetch_pass_seq.sv
module fetch_pass_seq
  import fft_fetch_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [1:0]       sel_i,
  output logic             busy_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [1:0]       lg_o,
  output logic             done_o
);

  localparam logic [CNT_W-1:0] LAST = {CNT_W{1'b1}};

  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [1:0]       lg_q, lg_d;
  logic             done_q, done_d;
  logic             en;

  assign en = busy_q | start_i | done_q;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    lg_d   = lg_q;
    done_d = 1'b0;
    if (busy_q) begin
      if (cnt_q == LAST) begin
        busy_d = 1'b0;
        cnt_d  = '0;
        done_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end else if (start_i) begin
      busy_d = 1'b1;
      cnt_d  = '0;
      lg_d   = unit_lg(sel_i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      lg_q   <= 2'd0;
      done_q <= 1'b0;
    end else if (en) begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      lg_q   <= lg_d;
      done_q <= done_d;
    end
  end

  assign busy_o = busy_q;
  assign cnt_o  = cnt_q;
  assign lg_o   = lg_q;
  assign done_o = done_q;

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R3
  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q)) |-> $stable(lg_q)); // R4
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start_i && cnt_q != LAST) |=> (busy_q && cnt_q == $past(cnt_q) + 1'b1)); // R4

endmodule

// File: rtl/fetch_addr_map.sv
module fetch_addr_map #(
  parameter int ADDR_W = 9,
  parameter int PAIR_W = 3,
  parameter int CNT_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [1:0]        lg_i,
  output logic [PAIR_W:0]   bank_lo_o,
  output logic [PAIR_W:0]   bank_hi_o,
  output logic [ADDR_W-1:0] addr_o
);

  logic [CNT_W-1:0]  off_mask;
  logic [CNT_W-1:0]  unit;
  logic [PAIR_W-1:0] pair;
  logic [ADDR_W-1:0] word;

  always_comb begin
    off_mask = (CNT_W'(1) << lg_i) - CNT_W'(1);
    unit     = cnt_i >> (ADDR_W + int'(lg_i));
    pair     = PAIR_W'((unit << lg_i) | (cnt_i & off_mask));
    word     = ADDR_W'(cnt_i >> lg_i);
  end

  assign bank_lo_o = busy_i ? {pair, 1'b0} : '0;
  assign bank_hi_o = busy_i ? {pair, 1'b1} : '0;
  assign addr_o    = busy_i ? word : '0;

  AST_R2_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && $past(busy_i) && lg_i == 2'd0) |-> (addr_o == $past(addr_o) + 1'b1)); // R6
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_i |-> (addr_o == '0 && bank_lo_o == '0 && bank_hi_o == '0)); // R3

endmodule

// File: rtl/fft_fetch_agen.sv
module fft_fetch_agen #(
  parameter int BANKS = 16,
  parameter int WORDS = 512,
  localparam int PAIR_W = $clog2(BANKS / 2),
  localparam int BANK_W = PAIR_W + 1,
  localparam int ADDR_W = $clog2(WORDS),
  localparam int CNT_W  = ADDR_W + PAIR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        radix_sel,
  output logic              fetch_valid,
  output logic [BANK_W-1:0] bank_lo,
  output logic [BANK_W-1:0] bank_hi,
  output logic [ADDR_W-1:0] word_addr,
  output logic              pass_done
);

  logic             busy;
  logic [CNT_W-1:0] cnt;
  logic [1:0]       lg;

  fetch_pass_seq #(.CNT_W(CNT_W)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start),
    .sel_i   (radix_sel),
    .busy_o  (busy),
    .cnt_o   (cnt),
    .lg_o    (lg),
    .done_o  (pass_done)
  );

  fetch_addr_map #(.ADDR_W(ADDR_W), .PAIR_W(PAIR_W), .CNT_W(CNT_W)) u_map (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy_i    (busy),
    .cnt_i     (cnt),
    .lg_i      (lg),
    .bank_lo_o (bank_lo),
    .bank_hi_o (bank_hi),
    .addr_o    (word_addr)
  );

  assign fetch_valid = busy;

  logic [PAIR_W-1:0] lo_pair;
  assign lo_pair = bank_lo[BANK_W-1:1];

  AST_VALID_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(fetch_valid && pass_done)); // R3
  AST_DONE_AFTER_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    pass_done |-> $past(fetch_valid)); // R3
  AST_R2_PAIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && $past(fetch_valid) && lg == 2'd0 && word_addr != '0) |-> $stable(bank_lo)); // R6
  AST_R4_PAIR_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && $past(fetch_valid) && lg == 2'd1) |-> (lo_pair[0] != $past(lo_pair[0]))); // R7
  AST_R8_PAIR_ROTATE: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && $past(fetch_valid) && lg == 2'd2) |-> (lo_pair[1:0] == $past(lo_pair[1:0]) + 2'd1)); // R8

endmodule

// File: tb/sim_fft_fetch_agen.sv
`timescale 1ns/1ps
module sim_fft_fetch_agen;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       start;
  logic [1:0] radix_sel;
  logic       fetch_valid;
  logic [3:0] bank_lo;
  logic [3:0] bank_hi;
  logic [8:0] word_addr;
  logic       pass_done;

  always #2.5 clk = ~clk;

  fft_fetch_agen u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .radix_sel(radix_sel),
    .fetch_valid(fetch_valid), .bank_lo(bank_lo), .bank_hi(bank_hi),
    .word_addr(word_addr), .pass_done(pass_done)
  );

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit check_en = 1'b0;

  // behavioural reference
  bit m_busy;
  int m_t;
  int m_lg;
  bit m_done;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0d", tag, act, exp, m_t);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy <= 1'b0; m_t <= 0; m_lg <= 0; m_done <= 1'b0;
    end else begin
      m_done <= 1'b0;
      if (m_busy) begin
        if (m_t == 4095) begin
          m_busy <= 1'b0; m_t <= 0; m_done <= 1'b1;
        end else begin
          m_t <= m_t + 1;
        end
      end else if (start) begin
        m_busy <= 1'b1;
        m_t    <= 0;
        m_lg   <= (radix_sel == 2'b01) ? 1 : (radix_sel == 2'b10) ? 2 : 0;
      end
    end
  end

  always @(negedge clk) begin
    if (check_en) begin
      int m, pair, eaddr, elo, ehi;
      string tag;
      m     = 1 << m_lg;
      pair  = m_busy ? ((m_t / (512 * m)) * m + (m_t % m)) : 0;
      eaddr = m_busy ? ((m_t / m) % 512) : 0;
      elo   = m_busy ? 2 * pair : 0;
      ehi   = m_busy ? 2 * pair + 1 : 0;
      tag   = !m_busy ? "R3 idle" : (m_lg == 0) ? "R6 radix2" :
              (m_lg == 1) ? "R7 radix4" : "R8 radix8";
      chk("R2 fetch_valid", int'(fetch_valid), int'(m_busy));
      chk("R3 pass_done", int'(pass_done), int'(m_done));
      chk({tag, " bank_lo"}, int'(bank_lo), elo);
      chk("R5 bank_hi", int'(bank_hi), ehi);
      if (m_busy && eaddr == 0 && m_t > 0)
        chk("R9 address wrap", int'(word_addr), eaddr);
      else
        chk({tag, " word_addr"}, int'(word_addr), eaddr);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic wait_done();
    do @(negedge clk); while (!pass_done);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; radix_sel = 2'b00;
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    chk("R1 valid", int'(fetch_valid), 0);
    chk("R1 done", int'(pass_done), 0);
    chk("R1 bank_lo", int'(bank_lo), 0);
    chk("R1 bank_hi", int'(bank_hi), 0);
    chk("R1 word_addr", int'(word_addr), 0);
    rst_n = 1'b1;
    check_en = 1'b1;
    repeat (4) @(negedge clk);

    // radix-2 pass; select flips and start repeats mid-pass (R4)
    radix_sel = 2'b00; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (700) @(negedge clk);
    radix_sel = 2'b10; start = 1'b1;
    @(negedge clk); start = 1'b0;
    radix_sel = 2'b01;
    wait_done();

    // radix-4 started in the done cycle (R3)
    radix_sel = 2'b01; start = 1'b1;
    @(negedge clk); start = 1'b0;
    wait_done();

    // radix-8 back to back
    radix_sel = 2'b10; start = 1'b1;
    @(negedge clk); start = 1'b0;
    radix_sel = 2'b00;
    wait_done();
    repeat (5) @(negedge clk);

    // reserved code behaves as radix-2 (R4)
    radix_sel = 2'b11; start = 1'b1;
    @(negedge clk); start = 1'b0;
    wait_done();
    repeat (5) @(negedge clk);

    check_en = 1'b0;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule